// File: doc/BRIEF.md
# Serial-to-Memory Access Bridge

This block sits on the device side of a four-wire serial link. It lets an external host read and write a 32-bit byte-addressed space through a simple synchronous memory port. Each transaction is framed by an active-low chip select. The host first sends one opcode byte and then a four-byte address. The opcode selects the direction and a data word of 2, 4 or 8 bytes. The serial clock is idle low. Inputs are sampled on its rising edge and the returned bit changes after its falling edge. All three serial inputs pass through a two-flop synchronizer into the system clock domain.

The wire carries each data word most significant byte first. The memory side is little-endian, so the bytes of every word are reversed between the wire and memory. A write transaction ends with one trailing pad byte. A read transaction has four pad bytes between the address and the first returned bit, and the bridge uses that time to fetch the first word. Burst commands move up to a fixed number of 8-byte words and advance the address after each word. 16-bit commands are honoured only inside one fixed address window.

The memory port presents a byte address, byte lane enables and 64-bit write data. Byte lane k carries the byte at address + k. A request is held until the memory answers with a ready pulse. Read data is taken in the ready cycle.

Top module: `spi_mem_bridge`

## Requirements
- R1: The first byte of a transaction is the opcode: 0x00 reads 16 bits, 0x01 writes 16 bits, 0x02 reads 32 bits, 0x03 writes 32 bits, 0x04 reads a burst and 0x05 writes a burst. Opcodes 0x06 to 0xFF cause no memory access, and their reads return zeros. Every memory request carries byte enables of 0x03, 0x0F or 0xFF.
- R2: A 32-bit write takes four data bytes w0..w3, in wire order, after the address. It issues one write at that address with mem_be 0x0F and mem_wdata[31:0] = {w0,w1,w2,w3}, so w3 is stored at the lowest address. Any data bytes after the first word produce no further write.
- R3: A read returns nothing during the four pad bytes after the address. The following bytes on the wire carry each word most significant byte first: wire byte j of an N-byte word is the memory byte at word address + N-1-j. A 32-bit read returns one word, and any further bytes on the wire are zero.
- R4: Burst commands use 8-byte words with mem_be 0xFF, and the address advances by 8 after each word. At most 30 words (240 bytes) are accessed per transaction. Burst write data beyond that limit is dropped, and burst read bytes beyond it are zero.
- R5: A 16-bit command uses one 2-byte word with mem_be 0x03. It accesses memory only when its address lies in [0x18020000, 0x18021000). Outside that window a write issues no request, and a read issues no request and returns zeros.
- R6: Deasserting chip select ends a transaction at any bit. A partly received word is discarded, and the next transaction is decoded from its first byte.
- R7: The trailing pad byte of a write transaction never causes a memory access.
- R8: Once mem_req is raised, it and mem_we, mem_addr, mem_be and mem_wdata stay unchanged until the cycle in which mem_rdy is high.
- R9: After reset, mem_req and spi_miso are low, and spi_miso stays low while chip select is deasserted.
- R10: The bridge samples spi_mosi on rising serial clock edges and changes spi_miso only after falling edges, so a host in clock mode 0 reads each returned bit correctly on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| mem_req | output | 1 | Memory request, held until mem_rdy |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the word |
| mem_be | output | 8 | Byte lane enables, lane k is address + k |
| mem_wdata | output | 64 | Write data, little-endian lanes |
| mem_rdata | input | 64 | Read data, valid when mem_rdy is high |
| mem_rdy | input | 1 | Memory completion pulse |

## Verification
The checks assume that the memory answers each request within one serial byte time. They also assume that the serial clock is slow enough for the synchronizer to see every edge: each half period lasts several system clocks. The stimulus keeps to both. The bench runs the serial clock at ten system clocks per half period, and its memory model raises mem_rdy three cycles after a request. The window and byte-enable properties also assume a host that never mixes opcodes inside a transaction, which framing by chip select guarantees. Chip select is always changed while the serial clock is low.

// File: rtl/spi_mem_bridge_pkg.sv
`timescale 1ns/1ps
package spi_mem_bridge_pkg;
    // opcode values decoded from the first byte of a transaction
    typedef enum logic [2:0] {
        OP_RD16  = 3'd0,
        OP_WR16  = 3'd1,
        OP_RD32  = 3'd2,
        OP_WR32  = 3'd3,
        OP_RDBST = 3'd4,
        OP_WRBST = 3'd5
    } op_e;

    localparam int unsigned LANES   = 8;          // widest data word in bytes
    localparam int unsigned DATA_W  = LANES * 8;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned HDR_END = 4;          // byte_cnt value of the last address byte
    localparam int unsigned RD_PAD  = 4;          // pad bytes before read data
endpackage

// File: rtl/spi_mem_bridge_sync.sv
`timescale 1ns/1ps
module spi_mem_bridge_sync #(
    parameter int unsigned    W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/spi_mem_bridge_decode.sv
`timescale 1ns/1ps
module spi_mem_bridge_decode
    import spi_mem_bridge_pkg::*;
#(
    parameter logic [31:0] WIN_BASE    = 32'h1802_0000,
    parameter logic [31:0] WIN_LIMIT   = 32'h1802_1000,
    parameter int unsigned BURST_WORDS = 30,
    parameter int unsigned CNT_W       = 5
) (
    input  logic [7:0]        op,
    input  logic [31:0]       addr,
    output logic              is_rd,
    output logic [3:0]        nbytes,
    output logic [CNT_W-1:0]  max_words,
    output logic              blocked,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] dmask
);
    logic known;
    logic narrow;
    logic in_win;

    always_comb begin
        known  = (op <= 8'(OP_WRBST));
        narrow = (op[2:1] == 2'b00);
        is_rd  = ~op[0];
        unique case (op[2:1])
            2'b00:   nbytes = 4'd2;
            2'b01:   nbytes = 4'd4;
            default: nbytes = 4'd8;
        endcase
        max_words = op[2] ? CNT_W'(BURST_WORDS) : CNT_W'(1);
        in_win    = (addr >= WIN_BASE) && (addr < WIN_LIMIT);
        blocked   = !known || (narrow && !in_win);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g]            = (4'(g) < nbytes);
        assign dmask[g*8 +: 8]  = {8{be[g]}};
    end
endmodule

// File: rtl/spi_mem_bridge.sv
`timescale 1ns/1ps
module spi_mem_bridge
    import spi_mem_bridge_pkg::*;
#(
    parameter logic [31:0] WIN_BASE        = 32'h1802_0000,
    parameter logic [31:0] WIN_LIMIT       = 32'h1802_1000,
    parameter int unsigned BURST_MAX_BYTES = 240
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sck,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_be,
    output logic [63:0] mem_wdata,
    input  logic [63:0] mem_rdata,
    input  logic        mem_rdy
);
    localparam int unsigned BURST_WORDS = BURST_MAX_BYTES / LANES;
    localparam int unsigned CNT_W       = $clog2(BURST_WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic              sck_prev;
        logic [2:0]        bit_cnt;
        logic [3:0]        byte_cnt;   // completed bytes, saturating
        logic [2:0]        wb;         // byte index inside the data word
        logic [CNT_W-1:0]  words;      // words fetched or written
        logic              blocked;
        logic [7:0]        op;
        logic [31:0]       addr;       // address of the next access
        logic [DATA_W-1:0] in_sr;
        logic [DATA_W-1:0] out_sr;
        logic [DATA_W-1:0] rbuf;
        logic              miso;
        logic              req;
        logic              we;
        logic [31:0]       maddr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
    } st_t;

    st_t s_q, s_d;

    logic cs_s, sck_s, mosi_s;
    spi_mem_bridge_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sck, spi_mosi}),
        .q     ({cs_s, sck_s, mosi_s})
    );

    logic [7:0]        byte_in;
    logic [31:0]       addr_cat;
    logic              is_rd, dec_blocked;
    logic [3:0]        nbytes;
    logic [CNT_W-1:0]  max_words;
    logic [LANES-1:0]  dec_be;
    logic [DATA_W-1:0] dmask;

    assign byte_in  = {s_q.in_sr[6:0], mosi_s};
    assign addr_cat = {s_q.addr[23:0], byte_in};

    spi_mem_bridge_decode #(
        .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT),
        .BURST_WORDS(BURST_WORDS), .CNT_W(CNT_W)
    ) u_dec (
        .op        (s_q.op),
        .addr      (addr_cat),
        .is_rd     (is_rd),
        .nbytes    (nbytes),
        .max_words (max_words),
        .blocked   (dec_blocked),
        .be        (dec_be),
        .dmask     (dmask)
    );

    logic              rise, fall, byte_done, data_ph, word_end, room;
    logic [6:0]        shamt;
    logic [DATA_W-1:0] rd_now;

    always_comb begin
        rise      = sck_s & ~s_q.sck_prev;
        fall      = ~sck_s & s_q.sck_prev;
        byte_done = rise && (s_q.bit_cnt == 3'd7);
        data_ph   = is_rd ? (s_q.byte_cnt >= 4'(HDR_END + 1 + RD_PAD))
                          : (s_q.byte_cnt >= 4'(HDR_END + 1));
        word_end  = ({1'b0, s_q.wb} == (nbytes - 4'd1));
        room      = !s_q.blocked && (s_q.words < max_words);
        shamt     = 7'd64 - {nbytes, 3'b000};

        s_d          = s_q;
        s_d.sck_prev = sck_s;
        rd_now       = s_q.rbuf;

        // memory completion
        if (s_q.req && mem_rdy) begin
            s_d.req = 1'b0;
            if (!s_q.we) begin
                rd_now     = mem_rdata & dmask;
                s_d.rbuf   = rd_now;
            end
        end

        if (cs_s) begin
            s_d.bit_cnt  = '0;
            s_d.byte_cnt = '0;
            s_d.wb       = '0;
            s_d.words    = '0;
            s_d.blocked  = 1'b1;
            s_d.out_sr   = '0;
            s_d.rbuf     = '0;
            s_d.miso     = 1'b0;
        end else begin
            if (rise) begin
                s_d.in_sr   = {s_q.in_sr[DATA_W-2:0], mosi_s};
                s_d.bit_cnt = s_q.bit_cnt + 3'd1;
            end
            if (byte_done) begin
                if (s_q.byte_cnt != 4'hF) s_d.byte_cnt = s_q.byte_cnt + 4'd1;
                if (s_q.byte_cnt == 4'd0) s_d.op = byte_in;
                else if (s_q.byte_cnt <= 4'(HDR_END)) s_d.addr = addr_cat;
                // header complete: latch access permission, fetch first read word
                if (s_q.byte_cnt == 4'(HDR_END)) begin
                    s_d.blocked = dec_blocked;
                    s_d.words   = '0;
                    if (is_rd && !dec_blocked) begin
                        s_d.req   = 1'b1;
                        s_d.we    = 1'b0;
                        s_d.maddr = addr_cat;
                        s_d.be    = dec_be;
                        s_d.addr  = addr_cat + 32'(nbytes);
                        s_d.words = CNT_ONE;
                    end
                end
                if (data_ph) s_d.wb = word_end ? 3'd0 : s_q.wb + 3'd1;
                // write: a full word has arrived
                if (!is_rd && data_ph && word_end && room) begin
                    s_d.req   = 1'b1;
                    s_d.we    = 1'b1;
                    s_d.maddr = s_q.addr;
                    s_d.be    = dec_be;
                    s_d.wdata = {s_q.in_sr[DATA_W-2:0], mosi_s} & dmask;
                    s_d.addr  = s_q.addr + 32'(nbytes);
                    s_d.words = s_q.words + CNT_ONE;
                end
                // read: next word starts, load shifter and prefetch
                if (is_rd && ((s_q.byte_cnt == 4'(HDR_END + RD_PAD)) || (data_ph && word_end))) begin
                    s_d.out_sr = rd_now << shamt;
                    s_d.rbuf   = '0;
                    if (room) begin
                        s_d.req   = 1'b1;
                        s_d.we    = 1'b0;
                        s_d.maddr = s_q.addr;
                        s_d.be    = dec_be;
                        s_d.addr  = s_q.addr + 32'(nbytes);
                        s_d.words = s_q.words + CNT_ONE;
                    end
                end
            end
            if (fall && is_rd && (s_q.byte_cnt >= 4'(HDR_END + 1 + RD_PAD))) begin
                s_d.miso   = s_q.out_sr[DATA_W-1];
                s_d.out_sr = {s_q.out_sr[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign spi_miso  = s_q.miso;
    assign mem_req   = s_q.req;
    assign mem_we    = s_q.we;
    assign mem_addr  = s_q.maddr;
    assign mem_be    = s_q.be;
    assign mem_wdata = s_q.wdata;
endmodule

// File: rtl/spi_mem_bridge_chk.sv
`timescale 1ns/1ps
module spi_mem_bridge_chk #(
    parameter logic [31:0] WIN_BASE  = 32'h1802_0000,
    parameter logic [31:0] WIN_LIMIT = 32'h1802_1000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        spi_cs_n,
    input logic        spi_miso,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_rdy,
    input logic [31:0] mem_addr,
    input logic [7:0]  mem_be,
    input logic [63:0] mem_wdata
);
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_be) && $stable(mem_wdata)));

    assert_be_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be == 8'h03 || mem_be == 8'h0F || mem_be == 8'hFF));

    assert_narrow_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_be == 8'h03) |-> (mem_addr >= WIN_BASE && mem_addr < WIN_LIMIT));

    assert_idle_miso_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);
endmodule

bind spi_mem_bridge spi_mem_bridge_chk #(
    .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_miso  (spi_miso),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_rdy   (mem_rdy),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata)
);

// File: tb/test_spi_mem_bridge.sv
`timescale 1ns/1ps
module test_spi_mem_bridge;
    localparam int HALF_NS = 40;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;
    logic        mem_req, mem_we, mem_rdy;
    logic [31:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    spi_mem_bridge i_spi_mem_bridge (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int acc_cnt = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem_img [logic [31:0]];
    int wait_cnt;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] rdb(input logic [31:0] a);
        return mem_img.exists(a) ? mem_img[a] : pat(a);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rdy   <= 1'b0;
            mem_rdata <= '0;
            wait_cnt  <= 0;
        end else if (mem_rdy) begin
            mem_rdy  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_req) begin
            if (wait_cnt == 2) begin
                mem_rdy <= 1'b1;
                for (int k = 0; k < 8; k++) begin
                    mem_rdata[k*8 +: 8] <= rdb(mem_addr + 32'(k));
                    if (mem_we && mem_be[k]) mem_img[mem_addr + 32'(k)] = mem_wdata[k*8 +: 8];
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [31:0] a;
        logic [7:0]  be;
        logic [63:0] d;
    } wr_t;
    wr_t   exp_q[$];
    string tag_q[$];

    task automatic expect_wr(input logic [31:0] a, input logic [7:0] be,
                             input logic [63:0] d, input string tag);
        exp_q.push_back('{a: a, be: be, d: d});
        tag_q.push_back(tag);
    endtask

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_rdy) begin
            acc_cnt++;
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected write addr", {32'h0, mem_addr}, 64'h0);
                end else begin
                    wr_t   e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(mem_addr == e.a, t, "write addr", {32'h0, mem_addr}, {32'h0, e.a});
                    check(mem_be == e.be, t, "write be", {56'h0, mem_be}, {56'h0, e.be});
                    check(mem_wdata == e.d, t, "write data", mem_wdata, e.d);
                end
            end
        end
    end

    // ---------------- serial driver ----------------
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    task automatic put_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = tx[b];
            #(HALF_NS);
            spi_sck = 1'b1;
            rx[b] = spi_miso;   // mode 0: host samples on the rising edge (R10)
            #(HALF_NS);
            spi_sck = 1'b0;
        end
    endtask

    task automatic start_txn(input logic [7:0] op, input logic [31:0] a);
        logic [7:0] r;
        @(negedge clk);
        spi_cs_n = 1'b0;
        #(HALF_NS);
        put_byte(op, r);
        for (int i = 3; i >= 0; i--) put_byte(a[i*8 +: 8], r);
    endtask

    task automatic end_txn();
        #(HALF_NS);
        spi_cs_n = 1'b1;
        #(4 * HALF_NS);
    endtask

    task automatic write_txn(input logic [7:0] op, input logic [31:0] a, input bit pad);
        logic [7:0] r;
        start_txn(op, a);
        foreach (tx_q[i]) put_byte(tx_q[i], r);
        if (pad) put_byte(8'h00, r);
        end_txn();
    endtask

    task automatic read_txn(input logic [7:0] op, input logic [31:0] a, input int n);
        logic [7:0] r;
        start_txn(op, a);
        for (int i = 0; i < 4; i++) put_byte(8'h00, r);
        rx_q.delete();
        for (int i = 0; i < n; i++) begin
            put_byte(8'h00, r);
            rx_q.push_back(r);
        end
        end_txn();
    endtask

    function automatic logic [63:0] word_of(input int base, input int n);
        logic [63:0] d = '0;
        for (int j = 0; j < n; j++) d = {d[55:0], tx_q[base + j]};
        return d;
    endfunction

    task automatic drain(input string tag);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, tag, "writes still expected", 64'(exp_q.size()), 64'h0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int base_acc;
        rst_n    = 1'b0;
        spi_cs_n = 1'b1;
        spi_sck  = 1'b0;
        spi_mosi = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(mem_req == 1'b0, "R9", "mem_req in reset", {63'h0, mem_req}, 64'h0);
        check(spi_miso == 1'b0, "R9", "miso in reset", {63'h0, spi_miso}, 64'h0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(mem_req == 1'b0, "R9", "mem_req after reset", {63'h0, mem_req}, 64'h0);

        // R2 / R7: 32-bit write with trailing pad byte
        tx_q = '{8'hAA, 8'hBB, 8'hCC, 8'hDD};
        expect_wr(32'h6003_0004, 8'h0F, 64'h0000_0000_AABB_CCDD, "R2");
        write_txn(8'h03, 32'h6003_0004, 1'b1);
        drain("R7");
        check(rdb(32'h6003_0004) == 8'hDD, "R2", "lowest address byte", {56'h0, rdb(32'h6003_0004)}, 64'hDD);

        // R3 / R10: 32-bit read back
        read_txn(8'h02, 32'h6003_0004, 4);
        check({rx_q[0], rx_q[1], rx_q[2], rx_q[3]} == 32'hAABB_CCDD, "R3",
              "32-bit read wire order", {32'h0, rx_q[0], rx_q[1], rx_q[2], rx_q[3]}, 64'hAABB_CCDD);

        // R4: burst write of two words
        tx_q.delete();
        for (int i = 0; i < 16; i++) tx_q.push_back(8'(8'h10 + i));
        expect_wr(32'h6003_0100, 8'hFF, word_of(0, 8), "R4");
        expect_wr(32'h6003_0108, 8'hFF, word_of(8, 8), "R4");
        write_txn(8'h05, 32'h6003_0100, 1'b1);
        drain("R4");

        // R4 / R10: burst read of unwritten pattern, three words
        read_txn(8'h04, 32'h6003_0200, 24);
        for (int j = 0; j < 24; j++) begin
            logic [31:0] ea;
            ea = 32'h6003_0200 + 32'((j / 8) * 8 + 7 - (j % 8));
            check(rx_q[j] == rdb(ea), "R10", "burst read byte", {56'h0, rx_q[j]}, {56'h0, rdb(ea)});
        end

        // R4: burst read of written data returns wire order
        read_txn(8'h04, 32'h6003_0100, 16);
        for (int j = 0; j < 16; j++)
            check(rx_q[j] == 8'(8'h10 + j), "R4", "burst readback", {56'h0, rx_q[j]}, 64'(8'h10 + j));

        // R5: 16-bit write and read inside the window
        tx_q = '{8'h12, 8'h34};
        expect_wr(32'h1802_0010, 8'h03, 64'h1234, "R5");
        write_txn(8'h01, 32'h1802_0010, 1'b1);
        drain("R5");
        read_txn(8'h00, 32'h1802_0010, 2);
        check({rx_q[0], rx_q[1]} == 16'h1234, "R5", "16-bit read", {48'h0, rx_q[0], rx_q[1]}, 64'h1234);

        // R5: last word inside the window is accessible
        read_txn(8'h00, 32'h1802_0FFE, 2);
        check({rx_q[0], rx_q[1]} == {rdb(32'h1802_0FFF), rdb(32'h1802_0FFE)}, "R5", "window top",
              {48'h0, rx_q[0], rx_q[1]}, {48'h0, rdb(32'h1802_0FFF), rdb(32'h1802_0FFE)});

        // R5: at the limit and below the base nothing is accessed
        base_acc = acc_cnt;
        tx_q = '{8'h55, 8'h66};
        write_txn(8'h01, 32'h1802_1000, 1'b1);
        read_txn(8'h00, 32'h1802_1000, 2);
        check({rx_q[0], rx_q[1]} == 16'h0, "R5", "read at limit", {48'h0, rx_q[0], rx_q[1]}, 64'h0);
        read_txn(8'h00, 32'h1801_FFFE, 2);
        check({rx_q[0], rx_q[1]} == 16'h0, "R5", "read below base", {48'h0, rx_q[0], rx_q[1]}, 64'h0);
        drain("R5");
        check(acc_cnt == base_acc, "R5", "accesses outside window", 64'(acc_cnt - base_acc), 64'h0);

        // R1: undefined opcodes
        base_acc = acc_cnt;
        tx_q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
        write_txn(8'h07, 32'h6003_0400, 1'b1);
        read_txn(8'h06, 32'h6003_0400, 4);
        check({rx_q[0], rx_q[1], rx_q[2], rx_q[3]} == 32'h0, "R1", "undefined read",
              {32'h0, rx_q[0], rx_q[1], rx_q[2], rx_q[3]}, 64'h0);
        drain("R1");
        check(acc_cnt == base_acc, "R1", "accesses for undefined opcode", 64'(acc_cnt - base_acc), 64'h0);

        // R6: abort inside a word, then a fresh transaction
        tx_q = '{8'h91, 8'h92, 8'h93, 8'h94, 8'h95};
        write_txn(8'h05, 32'h6003_0300, 1'b0);
        drain("R6");
        tx_q = '{8'h11, 8'h22, 8'h33, 8'h44};
        expect_wr(32'h6003_0300, 8'h0F, 64'h1122_3344, "R6");
        write_txn(8'h03, 32'h6003_0300, 1'b1);
        drain("R6");

        // R2 / R3: 32-bit commands move one word only
        tx_q = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hB1, 8'hB2, 8'hB3, 8'hB4};
        expect_wr(32'h6003_0500, 8'h0F, 64'hA1A2_A3A4, "R2");
        write_txn(8'h03, 32'h6003_0500, 1'b1);
        drain("R2");
        read_txn(8'h02, 32'h6003_0500, 8);
        check({rx_q[0], rx_q[1], rx_q[2], rx_q[3]} == 32'hA1A2_A3A4, "R3", "first word",
              {32'h0, rx_q[0], rx_q[1], rx_q[2], rx_q[3]}, 64'hA1A2_A3A4);
        check({rx_q[4], rx_q[5], rx_q[6], rx_q[7]} == 32'h0, "R3", "bytes past one word",
              {32'h0, rx_q[4], rx_q[5], rx_q[6], rx_q[7]}, 64'h0);

        // R4: burst limit of 30 words
        tx_q.delete();
        for (int i = 0; i < 248; i++) tx_q.push_back(8'(i + 1));
        for (int w = 0; w < 30; w++)
            expect_wr(32'h6004_0000 + 32'(w * 8), 8'hFF, word_of(w * 8, 8), "R4");
        write_txn(8'h05, 32'h6004_0000, 1'b1);
        drain("R4");
        check(!mem_img.exists(32'h6004_00F0), "R4", "word past limit written",
              {63'h0, mem_img.exists(32'h6004_00F0)}, 64'h0);
        read_txn(8'h04, 32'h6004_0000, 248);
        for (int j = 0; j < 248; j++) begin
            logic [7:0] e;
            e = (j < 240) ? 8'(j + 1) : 8'h00;
            if (j == 0 || j == 239 || j >= 240 || rx_q[j] != e)
                check(rx_q[j] == e, "R4", "long burst byte", {56'h0, rx_q[j]}, {56'h0, e});
        end

        @(negedge clk);
        check(spi_miso == 1'b0, "R9", "miso idle", {63'h0, spi_miso}, 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule